// File: doc/BRIEF.md
# SEC-DED Memory Read Checker

This block sits on the read return path of a memory protected by a single-error-correcting, double-error-detecting code. Each 32-bit word is stored with 7 check bits. When a word arrives with its check bits, the block computes a 7-bit syndrome. It sorts the result into four classes: clean, a single flipped data bit, a single flipped check bit, or an uncorrectable (multi-bit) error. A flipped data bit is repaired before the word goes back to the requester, provided correction is switched on.

The generator matrix lives in a shared package. The write-path check-bit generator uses that same package function, so both sides always agree on the code. Each data column has odd weight, at least three, and differs from every other column. Because of this, any even-weight syndrome, or any nonzero syndrome that matches no column, is classed as uncorrectable. An uncorrectable error on a read becomes an abort response. Writes are posted, so a write that shows an uncorrectable error only raises the interrupt.

When reporting is enabled, the first error captures its address and syndrome in two log registers and sets a sticky interrupt. Any further error while the interrupt is pending leaves the logs untouched and sets an overflow flag instead. Software clears the interrupt and the overflow flag one bit at a time with a write-one-to-clear strobe.

Top module: `ecc_rd_checker`

## Requirements
- R1: A word whose check bits match the generator gives a zero syndrome. It is returned unchanged, with outSbe, outMbe and outAbort all low, and the interrupt is not raised.
- R2: Syndrome bit 0 is the XOR of stored check bit 0 with data bits 0, 2, 5, 8 through 15, 17, 20, 22, 24, 26 and 28.
- R3: A single flipped data bit gives a syndrome of odd weight of at least 3. Each of the 32 data bits gives its own distinct syndrome. Data bit 0 gives 7'b1001001 (syndrome bits 6, 3 and 0 set). With corrEn high the flipped bit is inverted back, and outSbe is set.
- R4: With corrEn low, a single data-bit error is returned uncorrected, and outSbe is still set.
- R5: A flip of check bit j gives a syndrome with only bit j set. It is classed as single-bit (outSbe high), and the data passes through unchanged.
- R6: Any nonzero syndrome that matches no column is classed as multi-bit. This includes every double error and every unused odd-weight code. On a read it sets outMbe and outAbort, clears outSbe, and returns all-zero data.
- R7: With reportEn high and no interrupt pending, an error captures rdAddr into logAddr and the syndrome into logSyndrome, and sets irq.
- R8: With reportEn low, errors change neither irq nor the log registers.
- R9: While irq is pending, a further reported error leaves logAddr and logSyndrome unchanged and sets logOverflow. irq stays set until it is cleared.
- R10: A pulse on stsClrWr clears irq if stsClrBits bit 0 is set, and clears logOverflow if bit 1 is set. A zero bit leaves its flag unchanged.
- R11: A write (rdIsWrite high) with a multi-bit error sets outMbe but not outAbort. With reportEn high it sets irq (or logOverflow if irq is pending) without updating the logs.
- R12: All outputs are registered. outValid and the flags reflect the transaction presented with rdValid exactly one clock later, and outValid is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdValid | input | 1 | Transaction present on the inputs this cycle |
| rdIsWrite | input | 1 | Transaction is a posted write (no abort response) |
| rdAddr | input | ADDR_W | Transaction address, logged on error |
| rdData | input | 32 | Data word read from memory |
| rdCheck | input | 7 | Stored check bits read from memory |
| corrEn | input | 1 | Enable single-bit data correction |
| reportEn | input | 1 | Enable error logging and interrupt |
| stsClrWr | input | 1 | Write-one-to-clear strobe for status |
| stsClrBits | input | 2 | Bit 0 clears irq, bit 1 clears logOverflow |
| outValid | output | 1 | Registered result valid |
| outData | output | 32 | Returned (possibly corrected) data |
| outSbe | output | 1 | Single-bit error (data or check bit) |
| outMbe | output | 1 | Uncorrectable error |
| outAbort | output | 1 | Abort response for a read with multi-bit error |
| logAddr | output | ADDR_W | Address of the first logged error |
| logSyndrome | output | 7 | Syndrome of the first logged error |
| irq | output | 1 | Sticky error interrupt |
| logOverflow | output | 1 | A reported error arrived while irq was pending |

## Verification
The bound checker checks several rules on every clock:
- outSbe and outMbe are never set together.
- An abort always comes with outMbe and zero data.
- outValid trails rdValid by exactly one cycle.
- A pending interrupt and its logs stay stable until a clear.
- Nothing can raise the interrupt while reporting is off.

Only the directed scenarios can show that the code itself is right: the fixed row for syndrome bit 0, the syndrome of data bit 0, that all 32 single-bit syndromes are distinct, and that correction actually restores the word. They also cover the data-dependent behaviour: which error is logged first, the effect of each clear bit, and the write-side handling of multi-bit errors.

// File: rtl/secded_pkg.sv
package secded_pkg;

  localparam int DATA_W = 32;
  localparam int CHK_W  = 7;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_DATA1 = 2'd1,
    CLS_CHK1  = 2'd2,
    CLS_MULTI = 2'd3
  } errClass_t;

  // strobes from control to datapath
  typedef struct packed {
    logic captureLog;
    logic abortResp;
  } dpStrobe_t;

  // Syndrome produced by a flip of data bit idx (bit 6 .. bit 0).
  function automatic logic [CHK_W-1:0] colCode(input int idx);
    logic [CHK_W-1:0] c;
    case (idx)
      0:  c = 7'h49;  1:  c = 7'h0E;  2:  c = 7'h07;  3:  c = 7'h16;
      4:  c = 7'h26;  5:  c = 7'h0B;  6:  c = 7'h46;  7:  c = 7'h1A;
      8:  c = 7'h13;  9:  c = 7'h23;  10: c = 7'h43;  11: c = 7'h0D;
      12: c = 7'h15;  13: c = 7'h25;  14: c = 7'h45;  15: c = 7'h19;
      16: c = 7'h2A;  17: c = 7'h29;  18: c = 7'h4A;  19: c = 7'h32;
      20: c = 7'h31;  21: c = 7'h52;  22: c = 7'h51;  23: c = 7'h62;
      24: c = 7'h61;  25: c = 7'h1C;  26: c = 7'h1F;  27: c = 7'h2C;
      28: c = 7'h79;  29: c = 7'h4C;  30: c = 7'h34;  31: c = 7'h54;
      default: c = '0;
    endcase
    return c;
  endfunction

  // Data bits covered by check bit row.
  function automatic logic [DATA_W-1:0] rowMask(input int row);
    logic [DATA_W-1:0] m;
    logic [CHK_W-1:0]  c;
    m = '0;
    for (int i = 0; i < DATA_W; i++) begin
      c    = colCode(i);
      m[i] = c[row];
    end
    return m;
  endfunction

  // Check-bit generator shared with the write path.
  function automatic logic [CHK_W-1:0] encodeCheck(input logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] chk;
    for (int j = 0; j < CHK_W; j++) chk[j] = ^(d & rowMask(j));
    return chk;
  endfunction

endpackage

// File: rtl/ecc_rd_datapath.sv
module ecc_rd_datapath
  import secded_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdValid,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] rdData,
  input  logic [CHK_W-1:0]  rdCheck,
  input  logic              corrEn,
  input  dpStrobe_t         strobe,
  output errClass_t         errClass,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              outSbe,
  output logic              outMbe,
  output logic              outAbort,
  output logic [ADDR_W-1:0] logAddr,
  output logic [CHK_W-1:0]  logSyndrome
);

  logic [CHK_W-1:0]  syndrome;
  logic [DATA_W-1:0] colHit;
  logic [DATA_W-1:0] flipMask;
  logic              isSingle;

  // one parity tree per syndrome bit
  for (genvar j = 0; j < CHK_W; j++) begin : g_syn
    localparam logic [DATA_W-1:0] ROW = rowMask(j);
    assign syndrome[j] = (^(rdData & ROW)) ^ rdCheck[j];
  end

  // compare against every data column
  for (genvar i = 0; i < DATA_W; i++) begin : g_col
    localparam logic [CHK_W-1:0] COL = colCode(i);
    assign colHit[i] = (syndrome == COL);
  end

  always_comb begin
    if (syndrome == '0)        errClass = CLS_NONE;
    else if (|colHit)          errClass = CLS_DATA1;
    else if ($onehot(syndrome)) errClass = CLS_CHK1;
    else                       errClass = CLS_MULTI;
  end

  assign isSingle = (errClass == CLS_DATA1) || (errClass == CLS_CHK1);
  assign flipMask = (corrEn && errClass == CLS_DATA1) ? colHit : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
      outSbe   <= 1'b0;
      outMbe   <= 1'b0;
      outAbort <= 1'b0;
    end else begin
      outValid <= rdValid;
      if (rdValid) begin
        outData  <= strobe.abortResp ? '0 : (rdData ^ flipMask);
        outSbe   <= isSingle;
        outMbe   <= (errClass == CLS_MULTI);
        outAbort <= strobe.abortResp;
      end else begin
        outSbe   <= 1'b0;
        outMbe   <= 1'b0;
        outAbort <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      logAddr     <= '0;
      logSyndrome <= '0;
    end else if (strobe.captureLog) begin
      logAddr     <= rdAddr;
      logSyndrome <= syndrome;
    end
  end

endmodule

// File: rtl/ecc_rd_control.sv
module ecc_rd_control
  import secded_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      rdValid,
  input  logic      rdIsWrite,
  input  logic      reportEn,
  input  errClass_t errClass,
  input  logic      stsClrWr,
  input  logic [1:0] stsClrBits,
  output dpStrobe_t strobe,
  output logic      irq,
  output logic      logOverflow
);

  logic reportable;
  logic writeMulti;
  logic clrIrq;
  logic clrOvf;
  logic irqFree;
  logic setIrq;
  logic setOvf;

  assign reportable = rdValid && reportEn && (errClass != CLS_NONE);
  assign writeMulti = rdIsWrite && (errClass == CLS_MULTI);
  assign clrIrq     = stsClrWr && stsClrBits[0];
  assign clrOvf     = stsClrWr && stsClrBits[1];
  // a clear in the same cycle frees the log for the new error
  assign irqFree    = !irq || clrIrq;
  assign setIrq     = reportable && irqFree;
  assign setOvf     = reportable && !irqFree;

  always_comb begin
    strobe            = '0;
    strobe.captureLog = setIrq && !writeMulti;
    strobe.abortResp  = rdValid && !rdIsWrite && (errClass == CLS_MULTI);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irq         <= 1'b0;
      logOverflow <= 1'b0;
    end else begin
      if (setIrq)      irq <= 1'b1;
      else if (clrIrq) irq <= 1'b0;
      if (setOvf)      logOverflow <= 1'b1;
      else if (clrOvf) logOverflow <= 1'b0;
    end
  end

endmodule

// File: rtl/ecc_rd_checker.sv
module ecc_rd_checker
  import secded_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdValid,
  input  logic              rdIsWrite,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [31:0]       rdData,
  input  logic [6:0]        rdCheck,
  input  logic              corrEn,
  input  logic              reportEn,
  input  logic              stsClrWr,
  input  logic [1:0]        stsClrBits,
  output logic              outValid,
  output logic [31:0]       outData,
  output logic              outSbe,
  output logic              outMbe,
  output logic              outAbort,
  output logic [ADDR_W-1:0] logAddr,
  output logic [6:0]        logSyndrome,
  output logic              irq,
  output logic              logOverflow
);

  errClass_t errClass;
  dpStrobe_t strobe;

  ecc_rd_datapath #(.ADDR_W(ADDR_W)) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .rdValid    (rdValid),
    .rdAddr     (rdAddr),
    .rdData     (rdData),
    .rdCheck    (rdCheck),
    .corrEn     (corrEn),
    .strobe     (strobe),
    .errClass   (errClass),
    .outValid   (outValid),
    .outData    (outData),
    .outSbe     (outSbe),
    .outMbe     (outMbe),
    .outAbort   (outAbort),
    .logAddr    (logAddr),
    .logSyndrome(logSyndrome)
  );

  ecc_rd_control i_control (
    .clk        (clk),
    .rstN       (rstN),
    .rdValid    (rdValid),
    .rdIsWrite  (rdIsWrite),
    .reportEn   (reportEn),
    .errClass   (errClass),
    .stsClrWr   (stsClrWr),
    .stsClrBits (stsClrBits),
    .strobe     (strobe),
    .irq        (irq),
    .logOverflow(logOverflow)
  );

endmodule

// File: rtl/ecc_rd_checker_sva.sv
module ecc_rd_checker_sva #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              rdValid,
  input logic              reportEn,
  input logic              stsClrWr,
  input logic [1:0]        stsClrBits,
  input logic              outValid,
  input logic [31:0]       outData,
  input logic              outSbe,
  input logic              outMbe,
  input logic              outAbort,
  input logic [ADDR_W-1:0] logAddr,
  input logic [6:0]        logSyndrome,
  input logic              irq,
  input logic              logOverflow
);

  assert_class_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(outSbe && outMbe));

  assert_abort_is_multi_R6: assert property (@(posedge clk) disable iff (!rstN)
    outAbort |-> (outMbe && outData == '0));

  assert_valid_follows_R12: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> outValid);

  assert_valid_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |=> !outValid);

  assert_flags_need_valid_R12: assert property (@(posedge clk) disable iff (!rstN)
    (outSbe || outMbe || outAbort) |-> outValid);

  assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !(stsClrWr && stsClrBits[0])) |=> irq);

  assert_log_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !(stsClrWr && stsClrBits[0])) |=> ($stable(logAddr) && $stable(logSyndrome)));

  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (logOverflow && !(stsClrWr && stsClrBits[1])) |=> logOverflow);

  assert_silent_when_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!irq && !(rdValid && reportEn)) |=> !irq);

endmodule

bind ecc_rd_checker ecc_rd_checker_sva #(.ADDR_W(ADDR_W)) i_sva (
  .clk        (clk),
  .rstN       (rstN),
  .rdValid    (rdValid),
  .reportEn   (reportEn),
  .stsClrWr   (stsClrWr),
  .stsClrBits (stsClrBits),
  .outValid   (outValid),
  .outData    (outData),
  .outSbe     (outSbe),
  .outMbe     (outMbe),
  .outAbort   (outAbort),
  .logAddr    (logAddr),
  .logSyndrome(logSyndrome),
  .irq        (irq),
  .logOverflow(logOverflow)
);

// File: tb/test_ecc_rd_checker.sv
module test_ecc_rd_checker;

  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rstN;
  logic              rdValid, rdIsWrite;
  logic [ADDR_W-1:0] rdAddr;
  logic [31:0]       rdData;
  logic [6:0]        rdCheck;
  logic              corrEn, reportEn, stsClrWr;
  logic [1:0]        stsClrBits;
  logic              outValid, outSbe, outMbe, outAbort, irq, logOverflow;
  logic [31:0]       outData;
  logic [ADDR_W-1:0] logAddr;
  logic [6:0]        logSyndrome;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ecc_rd_checker #(.ADDR_W(ADDR_W)) i_ecc_rd_checker (
    .clk(clk), .rstN(rstN), .rdValid(rdValid), .rdIsWrite(rdIsWrite),
    .rdAddr(rdAddr), .rdData(rdData), .rdCheck(rdCheck), .corrEn(corrEn),
    .reportEn(reportEn), .stsClrWr(stsClrWr), .stsClrBits(stsClrBits),
    .outValid(outValid), .outData(outData), .outSbe(outSbe), .outMbe(outMbe),
    .outAbort(outAbort), .logAddr(logAddr), .logSyndrome(logSyndrome),
    .irq(irq), .logOverflow(logOverflow)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive at a falling edge, result visible at the next falling edge
  task automatic sendTxn(input logic [31:0] a, input logic [31:0] d,
                         input logic [6:0] c, input logic w);
    @(negedge clk);
    rdValid = 1'b1; rdIsWrite = w; rdAddr = a; rdData = d; rdCheck = c;
    @(negedge clk);
    rdValid = 1'b0; rdIsWrite = 1'b0;
  endtask

  task automatic clearSts(input logic [1:0] bits);
    @(negedge clk);
    stsClrWr = 1'b1; stsClrBits = bits;
    @(negedge clk);
    stsClrWr = 1'b0; stsClrBits = 2'b00;
  endtask

  task automatic testReset();
    chk("R12", "reset outValid", {31'b0, outValid}, 32'd0);
    chk("R7", "reset irq", {31'b0, irq}, 32'd0);
    chk("R9", "reset overflow", {31'b0, logOverflow}, 32'd0);
    chk("R7", "reset logAddr", logAddr, 32'd0);
    chk("R7", "reset logSyndrome", {25'b0, logSyndrome}, 32'd0);
  endtask

  task automatic testClean();
    logic [31:0] pats [4] = '{32'h0, 32'hFFFF_FFFF, 32'hA5A5_5A5A, 32'h1234_5678};
    corrEn = 1'b1; reportEn = 1'b1;
    clearSts(2'b11);
    foreach (pats[k]) begin
      sendTxn(32'h100 + k, pats[k], secded_pkg::encodeCheck(pats[k]), 1'b0);
      chk("R1", "clean data", outData, pats[k]);
      chk("R1", "clean flags", {29'b0, outSbe, outMbe, outAbort}, 32'd0);
      chk("R1", "clean irq", {31'b0, irq}, 32'd0);
    end
  endtask

  task automatic testRow0();
    logic [31:0] pats [4] = '{32'hDEAD_BEEF, 32'h0000_0001, 32'h8000_0004, 32'h0F0F_1234};
    logic [31:0] row0 = 32'h1552_FF25; // bits 0,2,5,8-15,17,20,22,24,26,28
    logic [6:0] c;
    reportEn = 1'b1;
    foreach (pats[k]) begin
      for (int b = 0; b < 2; b++) begin
        clearSts(2'b11);
        c = ~secded_pkg::encodeCheck(pats[k]);
        c[0] = b[0];
        sendTxn(32'h200, pats[k], c, 1'b0);
        chk("R2", "syndrome bit0", {31'b0, logSyndrome[0]},
            {31'b0, (^(pats[k] & row0)) ^ b[0]});
      end
    end
  endtask

  task automatic testSingleData();
    logic [31:0] base = 32'h3C96_A50F;
    logic [6:0]  seen [32];
    logic        dup;
    corrEn = 1'b1; reportEn = 1'b1;
    for (int i = 0; i < 32; i++) begin
      clearSts(2'b11);
      sendTxn(32'h4000 + i, base ^ (32'h1 << i), secded_pkg::encodeCheck(base), 1'b0);
      chk("R3", "corrected data", outData, base);
      chk("R3", "sbe/mbe/abort", {29'b0, outSbe, outMbe, outAbort}, 32'd4);
      chk("R7", "log addr", logAddr, 32'h4000 + i);
      chk("R7", "irq set", {31'b0, irq}, 32'd1);
      chk("R3", "odd weight >= 3",
          {31'b0, ($countones(logSyndrome) % 2 == 1) && ($countones(logSyndrome) >= 3)}, 32'd1);
      dup = 1'b0;
      for (int p = 0; p < i; p++) if (seen[p] == logSyndrome) dup = 1'b1;
      chk("R3", "distinct syndrome", {31'b0, dup}, 32'd0);
      seen[i] = logSyndrome;
      if (i == 0) chk("R3", "bit0 syndrome", {25'b0, logSyndrome}, 32'h49);
    end
  endtask

  task automatic testNoCorr();
    logic [31:0] d = 32'h5555_0000;
    corrEn = 1'b0;
    sendTxn(32'h500, d ^ 32'h80, secded_pkg::encodeCheck(d), 1'b0);
    chk("R4", "uncorrected data", outData, d ^ 32'h80);
    chk("R4", "sbe still set", {31'b0, outSbe}, 32'd1);
    corrEn = 1'b1;
  endtask

  task automatic testCheckBit();
    logic [31:0] d = 32'hCAFE_0123;
    reportEn = 1'b1;
    for (int j = 0; j < 7; j++) begin
      clearSts(2'b11);
      sendTxn(32'h600 + j, d, secded_pkg::encodeCheck(d) ^ (7'h1 << j), 1'b0);
      chk("R5", "data unchanged", outData, d);
      chk("R5", "sbe only", {29'b0, outSbe, outMbe, outAbort}, 32'd4);
      chk("R5", "onehot syndrome", {25'b0, logSyndrome}, 32'h1 << j);
    end
  endtask

  task automatic testMulti();
    logic [31:0] d = 32'h0BAD_F00D;
    reportEn = 1'b1;
    for (int i = 0; i < 27; i += 3) begin
      sendTxn(32'h700, d ^ (32'h1 << i) ^ (32'h1 << (i + 5)), secded_pkg::encodeCheck(d), 1'b0);
      chk("R6", "double flags", {29'b0, outSbe, outMbe, outAbort}, 32'd3);
      chk("R6", "abort data zero", outData, 32'd0);
    end
    // data bit + check bit double
    sendTxn(32'h700, d ^ 32'h10, secded_pkg::encodeCheck(d) ^ 7'h01, 1'b0);
    chk("R6", "data+check double", {29'b0, outSbe, outMbe, outAbort}, 32'd3);
    // unused odd-weight code: check bits 2,5,6 -> 7'h64
    clearSts(2'b11);
    sendTxn(32'h710, d, secded_pkg::encodeCheck(d) ^ 7'h64, 1'b0);
    chk("R6", "unused code flags", {29'b0, outSbe, outMbe, outAbort}, 32'd3);
    chk("R6", "unused code syndrome", {25'b0, logSyndrome}, 32'h64);
  endtask

  task automatic testReportOff();
    logic [31:0] d = 32'h7777_1111;
    logic [31:0] aBefore;
    logic [6:0]  sBefore;
    clearSts(2'b11);
    aBefore = logAddr; sBefore = logSyndrome;
    reportEn = 1'b0;
    sendTxn(32'h800, d ^ 32'h3, secded_pkg::encodeCheck(d), 1'b0);
    chk("R8", "no irq", {31'b0, irq}, 32'd0);
    chk("R8", "addr held", logAddr, aBefore);
    chk("R8", "syndrome held", {25'b0, logSyndrome}, {25'b0, sBefore});
    chk("R8", "flags still report", {31'b0, outMbe}, 32'd1);
    reportEn = 1'b1;
  endtask

  task automatic testOverflow();
    logic [31:0] d = 32'h2468_ACE0;
    clearSts(2'b11);
    sendTxn(32'h900, d, secded_pkg::encodeCheck(d) ^ 7'h02, 1'b0);
    sendTxn(32'h904, d ^ 32'h30, secded_pkg::encodeCheck(d), 1'b0);
    chk("R9", "first addr kept", logAddr, 32'h900);
    chk("R9", "first syndrome kept", {25'b0, logSyndrome}, 32'h02);
    chk("R9", "overflow set", {31'b0, logOverflow}, 32'd1);
    chk("R9", "irq held", {31'b0, irq}, 32'd1);
  endtask

  task automatic testClear();
    clearSts(2'b00);
    chk("R10", "zero bits keep irq", {31'b0, irq}, 32'd1);
    chk("R10", "zero bits keep ovf", {31'b0, logOverflow}, 32'd1);
    clearSts(2'b10);
    chk("R10", "ovf cleared", {31'b0, logOverflow}, 32'd0);
    chk("R10", "irq kept", {31'b0, irq}, 32'd1);
    clearSts(2'b01);
    chk("R10", "irq cleared", {31'b0, irq}, 32'd0);
  endtask

  task automatic testWriteMulti();
    logic [31:0] d = 32'h1357_9BDF;
    logic [31:0] aBefore;
    clearSts(2'b11);
    aBefore = logAddr;
    sendTxn(32'hA00, d ^ 32'h0101, secded_pkg::encodeCheck(d), 1'b1);
    chk("R11", "write mbe no abort", {29'b0, outSbe, outMbe, outAbort}, 32'd2);
    chk("R11", "write irq", {31'b0, irq}, 32'd1);
    chk("R11", "write log unchanged", logAddr, aBefore);
    sendTxn(32'hA04, d ^ 32'h0202, secded_pkg::encodeCheck(d), 1'b1);
    chk("R11", "write overflow", {31'b0, logOverflow}, 32'd1);
  endtask

  task automatic testLatency();
    logic [31:0] d = 32'h0F1E_2D3C;
    @(negedge clk);
    rdValid = 1'b1; rdAddr = 32'hB00; rdData = d; rdCheck = secded_pkg::encodeCheck(d);
    #5;
    chk("R12", "not yet valid", {31'b0, outValid}, 32'd0);
    @(negedge clk);
    rdValid = 1'b0;
    chk("R12", "valid after one edge", {31'b0, outValid}, 32'd1);
    chk("R12", "data after one edge", outData, d);
    @(negedge clk);
    chk("R12", "valid drops", {31'b0, outValid}, 32'd0);
  endtask

  initial begin
    rstN = 1'b0; rdValid = 1'b0; rdIsWrite = 1'b0; rdAddr = '0; rdData = '0;
    rdCheck = '0; corrEn = 1'b1; reportEn = 1'b1; stsClrWr = 1'b0; stsClrBits = 2'b00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testClean();
    testRow0();
    testSingleData();
    testNoCorr();
    testCheckBit();
    testMulti();
    testReportOff();
    testOverflow();
    testClear();
    testWriteMulti();
    testLatency();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule